// File: doc/BRIEF.md
# VGA Planar Write Datapath

This block forms the word that a planar VGA write stores into graphics memory. Memory is organised as four colour planes of eight bits each, packed into one 32-bit word. Plane p occupies bits 8p+7 down to 8p. From a single CPU data byte, the block builds a byte for each plane. It then merges each byte with the display latch under a bit mask, so that unmasked pixel positions keep the value last read from memory.

The block also holds the 32-bit display latch. Every VGA read loads the latch with the memory word that was read. Software can also read the latch and write it directly as a register. A write operation is qualified by `wr_valid`, and its result appears on `wr_out_data` one clock later, together with `wr_out_valid`. Two independent select bits choose the write mode: plain (rotate and set/reset), colour expansion, or masked set/reset. Masked set/reset takes priority when both selects are set.

Top module: `vga_wr_datapath`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the latch, `wr_out_valid` and `wr_out_data` are all cleared to zero at that edge.
- R2: `wr_out_valid` is high in exactly the cycle after a cycle with `wr_valid` high. `wr_out_data` changes only on such an edge and holds its value otherwise.
- R3: When `rd_valid` is high, the latch loads `mem_rd_data` at the clock edge. This takes priority over a software write in the same cycle.
- R4: When `latch_wr_en` is high and `rd_valid` is low, the latch loads `latch_wr_data`. When neither is high, the latch holds. `latch_q` always shows the latch.
- R5: Where the effective mask bit is 0, that bit position in every plane (plane p = bits 8p+7:8p) is copied from the latch. Where it is 1, the bit comes from the plane's data byte.
- R6: With neither mode select set, the data byte is `cpu_data` rotated right by `rot_count` positions, and the effective mask is `bit_mask`.
- R7: With neither mode select set, a plane whose `sr_enable` bit is 1 uses a byte of all copies of its `sr_value` bit in place of the rotated data.
- R8: With only `mode2_sel` set, plane p uses a byte of all copies of `cpu_data[p]`. Rotation and set/reset are ignored, and the effective mask is `bit_mask`.
- R9: With `mode3_sel` set, plane p uses a byte of all copies of `sr_value[p]`, regardless of `sr_enable`. The effective mask is the rotated `cpu_data` ANDed with `bit_mask`.
- R10: When both mode selects are set, the result equals the `mode3_sel` behaviour of R9.
- R11: A write uses the latch value held before the clock edge, even when the latch is loaded at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | VGA read completes; load latch from memory data |
| mem_rd_data | input | 32 | Memory word returned by the VGA read |
| latch_wr_en | input | 1 | Software write strobe for the latch |
| latch_wr_data | input | 32 | Software value for the latch |
| latch_q | output | 32 | Current latch contents (software readable) |
| wr_valid | input | 1 | A write operation is presented this cycle |
| cpu_data | input | 8 | CPU data byte |
| rot_count | input | 3 | Right-rotate amount for the CPU byte |
| sr_value | input | 4 | Per-plane set/reset colour bit |
| sr_enable | input | 4 | Per-plane set/reset enable |
| bit_mask | input | 8 | Bit positions taken from the data (1) or the latch (0) |
| mode2_sel | input | 1 | Colour-expansion write mode select |
| mode3_sel | input | 1 | Masked set/reset write mode select |
| wr_out_valid | output | 1 | Registered write result valid |
| wr_out_data | output | 32 | Registered write result, four planes |

## Verification
On every cycle, the assertions check the timing contract: output valid follows the input strobe by one edge, and the output word holds between writes. They also check latch load priority and hold, the all-latch result when the bit mask is zero, and full colour expansion in mode 2 under an all-ones mask. Three behaviours depend on exact data values and are shown only by the bench's scenarios, which compare against a reference function: rotation amounts, the interaction of per-plane set/reset with the mask, and the rotated-data mask of mode 3. The same applies to the same-edge case where a read reloads the latch while a write consumes its old value.

// File: rtl/vga_wr_pkg.sv
// Package: shared types and helpers for the VGA planar write datapath.
// Assumes planes are packed little-end first: plane p at bits p*PLANE_W.
package vga_wr_pkg;

    // Write-mode selection after priority resolution
    typedef enum logic [1:0] {
        WM_PLAIN      = 2'd0,  // rotate + per-plane set/reset
        WM_EXPAND     = 2'd1,  // CPU low bits expanded to plane colour
        WM_MASKED_SR  = 2'd2   // set/reset colour, rotated data as mask
    } wr_mode_e;

    // Resolve the two independent selects; masked set/reset wins
    function automatic wr_mode_e resolve_mode(input logic sel2, input logic sel3);
        if (sel3)
            return WM_MASKED_SR;
        else if (sel2)
            return WM_EXPAND;
        else
            return WM_PLAIN;
    endfunction

endpackage

// File: rtl/vga_byte_rotator.sv
// Module: right-rotates a byte-wide (PLANE_W) value by a run-time amount.
// Assumes ROT_W is wide enough to express PLANE_W-1; purely combinational.
module vga_byte_rotator #(
    parameter int PLANE_W = 8,
    localparam int ROT_W  = $clog2(PLANE_W)
) (
    input  logic [PLANE_W-1:0] din,
    input  logic [ROT_W-1:0]   amount,
    output logic [PLANE_W-1:0] dout
);

    logic [2*PLANE_W-1:0] doubled;
    logic [2*PLANE_W-1:0] shifted;

    // Duplicate the value so a right shift wraps low bits into the top
    always_comb begin
        doubled = {din, din};
        shifted = doubled >> amount;
        dout    = shifted[PLANE_W-1:0];
    end

endmodule

// File: rtl/vga_display_latch.sv
// Module: 32-bit display latch. A VGA read load has priority over a
// software register write; otherwise the latch holds. Sync active-low reset.
module vga_display_latch #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_rd,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              load_sw,
    input  logic [WORD_W-1:0] sw_word,
    output logic [WORD_W-1:0] q
);

    // Update the latch: reset, then read load, then software write
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load_rd)
            q <= rd_word;
        else if (load_sw)
            q <= sw_word;
    end

endmodule

// File: rtl/vga_plane_lane.sv
// Module: builds and merges one plane's byte. Selects the plane data
// according to the resolved mode, then takes masked-off bits from the latch.
// Assumes the effective mask is computed outside (shared by all planes).
module vga_plane_lane
    import vga_wr_pkg::*;
#(
    parameter int PLANE_W = 8
) (
    input  wr_mode_e           mode,
    input  logic [PLANE_W-1:0] rot_byte,
    input  logic               cpu_bit,
    input  logic               sr_bit,
    input  logic               sr_en_bit,
    input  logic [PLANE_W-1:0] eff_mask,
    input  logic [PLANE_W-1:0] latch_byte,
    output logic [PLANE_W-1:0] plane_out
);

    logic [PLANE_W-1:0] plane_data;

    // Choose the plane's source byte for the active mode
    always_comb begin
        unique case (mode)
            WM_EXPAND:    plane_data = {PLANE_W{cpu_bit}};
            WM_MASKED_SR: plane_data = {PLANE_W{sr_bit}};
            default:      plane_data = sr_en_bit ? {PLANE_W{sr_bit}} : rot_byte;
        endcase
    end

    // Merge data with latch under the effective mask
    always_comb begin
        plane_out = (plane_data & eff_mask) | (latch_byte & ~eff_mask);
    end

endmodule

// File: rtl/vga_wr_datapath.sv
// Module: top of the VGA planar write datapath. Owns the display latch,
// rotates the CPU byte, resolves the write mode, forms the effective mask
// and merges each plane. Result is registered: one cycle from wr_valid.
// Assumes PLANES <= PLANE_W (mode 2 uses one CPU bit per plane).
module vga_wr_datapath
    import vga_wr_pkg::*;
#(
    parameter int PLANES  = 4,
    parameter int PLANE_W = 8,
    localparam int WORD_W = PLANES * PLANE_W,
    localparam int ROT_W  = $clog2(PLANE_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_valid,
    input  logic [WORD_W-1:0]  mem_rd_data,
    input  logic               latch_wr_en,
    input  logic [WORD_W-1:0]  latch_wr_data,
    output logic [WORD_W-1:0]  latch_q,
    input  logic               wr_valid,
    input  logic [PLANE_W-1:0] cpu_data,
    input  logic [ROT_W-1:0]   rot_count,
    input  logic [PLANES-1:0]  sr_value,
    input  logic [PLANES-1:0]  sr_enable,
    input  logic [PLANE_W-1:0] bit_mask,
    input  logic               mode2_sel,
    input  logic               mode3_sel,
    output logic               wr_out_valid,
    output logic [WORD_W-1:0]  wr_out_data
);

    wr_mode_e           mode;
    logic [PLANE_W-1:0] rot_byte;
    logic [PLANE_W-1:0] eff_mask;
    logic [WORD_W-1:0]  merged;

    vga_display_latch #(.WORD_W(WORD_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_rd (rd_valid),
        .rd_word (mem_rd_data),
        .load_sw (latch_wr_en),
        .sw_word (latch_wr_data),
        .q       (latch_q)
    );

    vga_byte_rotator #(.PLANE_W(PLANE_W)) u_rot (
        .din    (cpu_data),
        .amount (rot_count),
        .dout   (rot_byte)
    );

    // Resolve mode priority and the mask shared by all planes
    always_comb begin
        mode     = resolve_mode(mode2_sel, mode3_sel);
        eff_mask = (mode == WM_MASKED_SR) ? (rot_byte & bit_mask) : bit_mask;
    end

    // One lane per plane
    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        vga_plane_lane #(.PLANE_W(PLANE_W)) u_lane (
            .mode       (mode),
            .rot_byte   (rot_byte),
            .cpu_bit    (cpu_data[p]),
            .sr_bit     (sr_value[p]),
            .sr_en_bit  (sr_enable[p]),
            .eff_mask   (eff_mask),
            .latch_byte (latch_q[p*PLANE_W +: PLANE_W]),
            .plane_out  (merged[p*PLANE_W +: PLANE_W])
        );
    end

    // Register the valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_out_valid <= 1'b0;
        else
            wr_out_valid <= wr_valid;
    end

    // Capture the merged word only on a write
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_out_data <= '0;
        else if (wr_valid)
            wr_out_data <= merged;
    end

endmodule

// File: rtl/vga_wr_datapath_chk.sv
// Checker: cycle-level properties of vga_wr_datapath, bound to every instance.
module vga_wr_datapath_chk #(
    parameter int PLANES  = 4,
    parameter int PLANE_W = 8,
    localparam int WORD_W = PLANES * PLANE_W,
    localparam int ROT_W  = $clog2(PLANE_W)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_valid,
    input logic [WORD_W-1:0]  mem_rd_data,
    input logic               latch_wr_en,
    input logic [WORD_W-1:0]  latch_wr_data,
    input logic [WORD_W-1:0]  latch_q,
    input logic               wr_valid,
    input logic [PLANE_W-1:0] cpu_data,
    input logic [ROT_W-1:0]   rot_count,
    input logic [PLANES-1:0]  sr_value,
    input logic [PLANES-1:0]  sr_enable,
    input logic [PLANE_W-1:0] bit_mask,
    input logic               mode2_sel,
    input logic               mode3_sel,
    input logic               wr_out_valid,
    input logic [WORD_W-1:0]  wr_out_data
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!wr_out_valid && wr_out_data == '0 && latch_q == '0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> wr_out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !wr_out_valid);

    assert_data_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(wr_out_data));

    assert_read_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> latch_q == $past(mem_rd_data));

    assert_sw_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_wr_en && !rd_valid) |=> latch_q == $past(latch_wr_data));

    assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_wr_en && !rd_valid) |=> $stable(latch_q));

    assert_zero_mask_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && bit_mask == '0) |=> wr_out_data == $past(latch_q));

    for (genvar p = 0; p < PLANES; p++) begin : g_chk
        assert_expand_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid && mode2_sel && !mode3_sel && bit_mask == '1) |=>
            wr_out_data[p*PLANE_W +: PLANE_W] == {PLANE_W{$past(cpu_data[p])}});
    end

endmodule

bind vga_wr_datapath vga_wr_datapath_chk #(.PLANES(PLANES), .PLANE_W(PLANE_W)) u_chk (.*);

// File: tb/vga_wr_datapath_tb.sv
module vga_wr_datapath_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        latch_wr_en = 1'b0;
    logic [31:0] latch_wr_data = '0;
    logic [31:0] latch_q;
    logic        wr_valid = 1'b0;
    logic [7:0]  cpu_data = '0;
    logic [2:0]  rot_count = '0;
    logic [3:0]  sr_value = '0;
    logic [3:0]  sr_enable = '0;
    logic [7:0]  bit_mask = '0;
    logic        mode2_sel = 1'b0;
    logic        mode3_sel = 1'b0;
    logic        wr_out_valid;
    logic [31:0] wr_out_data;

    int checks = 0;
    int failures = 0;
    logic [31:0] m_latch = '0;
    logic [31:0] m_out = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vga_wr_datapath u_dut (.*);

    function automatic logic [7:0] ror8(input logic [7:0] v, input logic [2:0] n);
        logic [7:0] r = v;
        for (int i = 0; i < n; i++) r = {r[0], r[7:1]};
        return r;
    endfunction

    function automatic logic [31:0] model(input logic [7:0] cd, input logic [2:0] rc,
            input logic [3:0] sr, input logic [3:0] sre, input logic [7:0] bm,
            input logic m2, input logic m3, input logic [31:0] lat);
        logic [31:0] res;
        logic [7:0] rot = ror8(cd, rc);
        logic [7:0] msk = m3 ? (rot & bm) : bm;
        for (int p = 0; p < 4; p++) begin
            logic [7:0] d;
            if (m3)            d = {8{sr[p]}};
            else if (m2)       d = {8{cd[p]}};
            else if (sre[p])   d = {8{sr[p]}};
            else               d = rot;
            res[p*8 +: 8] = (d & msk) | (lat[p*8 +: 8] & ~msk);
        end
        return res;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model, step edge, check after it
    task automatic cycle(input logic rd, input logic [31:0] md, input logic sw,
            input logic [31:0] sd, input logic wv, input logic [7:0] cd,
            input logic [2:0] rc, input logic [3:0] sr, input logic [3:0] sre,
            input logic [7:0] bm, input logic m2, input logic m3, input string tag);
        logic [31:0] exp_out;
        @(negedge clk);
        rd_valid = rd; mem_rd_data = md; latch_wr_en = sw; latch_wr_data = sd;
        wr_valid = wv; cpu_data = cd; rot_count = rc; sr_value = sr;
        sr_enable = sre; bit_mask = bm; mode2_sel = m2; mode3_sel = m3;
        exp_out = model(cd, rc, sr, sre, bm, m2, m3, m_latch);
        if (wv) m_out = exp_out;
        if (rd) m_latch = md;
        else if (sw) m_latch = sd;
        @(posedge clk);
        #1;
        check("R2 valid", {31'd0, wr_out_valid}, {31'd0, wv});
        check(tag, wr_out_data, m_out);
        check(rd ? "R3 latch" : "R4 latch", latch_q, m_latch);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 latch", latch_q, 32'h0);
        check("R1 data", wr_out_data, 32'h0);
        check("R1 valid", {31'd0, wr_out_valid}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: software write, then hold
        cycle(0, '0, 1, 32'hA5C3_0F96, 0, 0, 0, 0, 0, 0, 0, 0, "R4 sw");
        cycle(0, '0, 0, 32'h1111_1111, 0, 0, 0, 0, 0, 0, 0, 0, "R4 hold");
        // R3: read load wins over software write
        cycle(1, 32'h3C5A_F00F, 1, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, 0, 0, "R3 prio");
        // R5: zero mask copies latch everywhere
        cycle(0, '0, 0, '0, 1, 8'hFF, 0, 4'hF, 4'hF, 8'h00, 0, 0, "R5 zero mask");
        // R6: rotate right by 3, full mask
        cycle(0, '0, 0, '0, 1, 8'h81, 3'd3, 0, 0, 8'hFF, 0, 0, "R6 rotate");
        // R6 with partial mask
        cycle(0, '0, 0, '0, 1, 8'hF0, 3'd7, 0, 0, 8'h3C, 0, 0, "R6 partial");
        // R7: set/reset on planes 0 and 2
        cycle(0, '0, 0, '0, 1, 8'h5A, 3'd1, 4'b0100, 4'b0101, 8'hF0, 0, 0, "R7 setreset");
        // R8: expansion ignores rotate and set/reset
        cycle(0, '0, 0, '0, 1, 8'hF6, 3'd5, 4'hF, 4'hF, 8'hFF, 1, 0, "R8 expand");
        // R9: masked set/reset, sr_enable ignored
        cycle(0, '0, 0, '0, 1, 8'h0F, 3'd2, 4'b1010, 4'h0, 8'hE7, 0, 1, "R9 masked");
        // R10: both selects -> mode 3
        cycle(0, '0, 0, '0, 1, 8'hC3, 3'd4, 4'b0110, 4'hF, 8'hFF, 1, 1, "R10 priority");
        // R11: read and write same edge, write uses old latch
        cycle(1, 32'hFFFF_FFFF, 0, '0, 1, 8'h00, 0, 0, 0, 8'h0F, 0, 0, "R11 old latch");
        // R2: idle cycle keeps output
        cycle(0, '0, 0, '0, 0, 8'hAA, 3'd1, 4'h3, 4'h3, 8'hFF, 0, 1, "R2 hold");

        for (int i = 0; i < 600; i++) begin
            logic rd = ($urandom % 5) == 0;
            logic sw = ($urandom % 5) == 0;
            logic wv = ($urandom % 4) != 0;
            logic m2 = $urandom % 2;
            logic m3 = ($urandom % 3) == 0;
            logic [3:0] sre = $urandom;
            string tag;
            if (m3 && m2) tag = "R10 rand";
            else if (m3) tag = "R9 rand";
            else if (m2) tag = "R8 rand";
            else if (sre != 0) tag = "R7 rand";
            else tag = "R6 rand";
            if (!wv) tag = "R2 rand hold";
            cycle(rd, $urandom, sw, $urandom, wv, 8'($urandom), 3'($urandom),
                  4'($urandom), sre, 8'($urandom), m2, m3, tag);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
    end

endmodule